// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory bus of a small 8-bit controller. It performs code fetches, data reads and data writes against a 64 KB code space and a 64 KB data space. Time is divided into machine cycles of twelve clock periods, and each access fills exactly one machine cycle. The address high byte stays on a dedicated port for the whole access. The address low byte and the data byte share a second port at different times. A latch-enable strobe marks the window in which an external transparent latch can capture the low address byte.

Code fetches are qualified by an active-low program-store strobe. Data reads use an active-low read strobe and data writes use an active-low write strobe. A select input tells the block that code lives in internal memory. Code requests then never reach the bus. The block also filters the raw reset pin. It raises a qualified reset only after that pin has been high for two whole machine cycles.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst_n` is low, and afterwards until a request is accepted, the bus is idle: `busy` and `done` are 0, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `lo_oe` is 0 and `hi_out` is 0x00.
- R2: `req_kind` encodes 2'b00 code fetch, 2'b01 data read, 2'b10 data write and 2'b11 no operation. A request is taken only on the last clock (clock 11) of a machine cycle. `busy` is then high for exactly 12 clocks, numbered 0 to 11. `done` is a one-clock pulse in the clock after clock 11.
- R3: `hi_out` equals address bits 15:8 on every clock of an access.
- R4: `ale` is high on clocks 0 to 2 of an access. `lo_oe` is high with `lo_out` equal to address bits 7:0 on clocks 0 to 3. `ale` is never high together with any strobe.
- R5: For a code fetch or a data read, `lo_oe` is 0 on clocks 4 to 11 and the strobe is low on clocks 5 to 10. `lo_in` is sampled on the clock edge that ends clock 10 and appears on `rdata`.
- R6: For a data write, `lo_out` carries the write data with `lo_oe` high on clocks 4 to 11, and `wr_n` is low on clocks 5 to 10. `rdata` keeps its previous value.
- R7: `psen_n` goes low only for code fetches, `rd_n` only for data reads and `wr_n` only for data writes. At most one of the three is low at any time.
- R8: A code request while `code_int` is 1 is ignored, and so is a request with kind 2'b11. In both cases `busy` stays 0, no strobe goes low and `ale` stays 0.
- R9: A request held high through clock 11 of an access starts the next access immediately. `busy` stays high, and `ale` rises in the same clock that `done` pulses.
- R10: `rst_qual` goes high after `ext_rst` has been sampled high on 24 consecutive clock edges. A shorter pulse leaves it low. The count restarts whenever `ext_rst` is sampled low.
- R11: While `rst_qual` is high no request is accepted and any access in progress stops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Raw external reset pin, active high |
| code_int | input | 1 | 1: code comes from internal memory |
| req | input | 1 | Access request |
| req_kind | input | 2 | Access kind, encoded as in R2 |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished pulse |
| rdata | output | 8 | Byte returned by the last read or fetch |
| rst_qual | output | 1 | Qualified reset |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_out | output | 8 | Address high byte port |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |

## Verification
The bench walks every clock of each access and compares each bus pin with the expected phase pattern. A controller off by one phase would sample the data after the strobe has risen, or would drive the low port against the memory. Reset pulses of 23 clocks, and two 20-clock pulses split by one low clock, are aimed at a filter that fires early or fails to restart its count. Requests held through clock 11 test back-to-back starts. Ignored code and no-op requests catch a controller that issues a stray program-store or latch pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_CODE  = 2'b00,
    XK_READ  = 2'b01,
    XK_WRITE = 2'b10,
    XK_NONE  = 2'b11
  } xkind_e;

  // Phase windows are derived from the machine-cycle length mc.
  function automatic int ale_last(input int mc);  return mc / 4 - 1; endfunction
  function automatic int addr_last(input int mc); return mc / 4;     endfunction
  function automatic int stb_first(input int mc); return mc / 4 + 2; endfunction
  function automatic int stb_last(input int mc);  return mc - 2;     endfunction

  function automatic logic ale_on(input int ph, input int mc);
    return ph <= ale_last(mc);
  endfunction

  function automatic logic addr_on(input int ph, input int mc);
    return ph <= addr_last(mc);
  endfunction

  function automatic logic stb_on(input int ph, input int mc);
    return (ph >= stb_first(mc)) && (ph <= stb_last(mc));
  endfunction
endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen #(
  parameter int MC_CLKS = 12,
  localparam int PW = $clog2(MC_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [PW-1:0] phase,
  output logic          mc_edge
);
  localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);

  assign mc_edge = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr)     phase <= '0;
    else if (mc_edge) phase <= '0;
    else              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/xbus_rst_filter.sv
module xbus_rst_filter #(
  parameter int MC_CLKS = 12,
  parameter int RST_MCS = 2,
  localparam int THRESH = MC_CLKS * RST_MCS,
  localparam int CW = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst,
  output logic rst_qual
);
  localparam logic [CW-1:0] TOP = CW'(THRESH);
  logic [CW-1:0] cnt;

  assign rst_qual = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!ext_rst) cnt <= '0;
    else if (!rst_qual) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int MC_CLKS = 12,
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int PW = $clog2(MC_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] phase,
  input  logic          mc_edge,
  input  logic          code_int,
  input  logic          req,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] lo_in,
  output logic          start,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0] lo_out,
  output logic          lo_oe
);
  xkind_e        kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          act;
  logic          req_ok, stb, in_addr, sample;
  int            ph;

  assign ph      = int'(phase);
  assign req_ok  = req && (xkind_e'(req_kind) != XK_NONE) &&
                   !((xkind_e'(req_kind) == XK_CODE) && code_int);
  assign start   = mc_edge && req_ok && !clr;
  assign stb     = act && stb_on(ph, MC_CLKS);
  assign in_addr = act && addr_on(ph, MC_CLKS);
  assign sample  = act && (ph == stb_last(MC_CLKS)) && (kind_q != XK_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      done    <= 1'b0;
      kind_q  <= XK_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      done <= act && mc_edge && !clr;
      if (clr) act <= 1'b0;
      else if (mc_edge) act <= start;
      if (start) begin
        kind_q  <= xkind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (sample && !clr) rdata <= lo_in;
    end
  end

  assign busy   = act;
  assign ale    = act && ale_on(ph, MC_CLKS);
  assign psen_n = !(stb && kind_q == XK_CODE);
  assign rd_n   = !(stb && kind_q == XK_READ);
  assign wr_n   = !(stb && kind_q == XK_WRITE);
  assign hi_out = act ? addr_q[AW-1:DW] : '0;
  assign lo_oe  = in_addr || (act && kind_q == XK_WRITE);
  assign lo_out = in_addr ? addr_q[DW-1:0] :
                  (lo_oe ? wdata_q : '0);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int MC_CLKS = 12,
  parameter int RST_MCS = 2,
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_rst,
  input  logic          code_int,
  input  logic          req,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          rst_qual,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0] lo_out,
  output logic          lo_oe,
  input  logic [DW-1:0] lo_in
);
  localparam int PW = $clog2(MC_CLKS);

  logic [PW-1:0] phase;
  logic          mc_edge;
  logic          acc_start;

  xbus_rst_filter #(.MC_CLKS(MC_CLKS), .RST_MCS(RST_MCS)) u_rst (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .rst_qual(rst_qual)
  );

  xbus_phase_gen #(.MC_CLKS(MC_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(rst_qual), .phase(phase), .mc_edge(mc_edge)
  );

  xbus_seq #(.MC_CLKS(MC_CLKS), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(rst_qual), .phase(phase), .mc_edge(mc_edge),
    .code_int(code_int), .req(req), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .lo_in(lo_in), .start(acc_start), .busy(busy),
    .done(done), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .hi_out(hi_out), .lo_out(lo_out), .lo_oe(lo_oe)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int HW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_rst,
  input logic          rst_qual,
  input logic          mc_edge,
  input logic          busy,
  input logic          done,
  input logic          ale,
  input logic          psen_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          lo_oe,
  input logic [HW-1:0] hi_out
);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!psen_n || !rd_n) |-> !lo_oe);

  p_ale_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));

  p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n || rst_qual)
    (busy && !mc_edge) |=> (busy && $stable(hi_out)));

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_qual_needs_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_qual |-> $past(ext_rst));

  p_reset_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_qual |=> !busy);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HW(AW - DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .rst_qual(rst_qual),
  .mc_edge(mc_edge), .busy(busy), .done(done), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .lo_oe(lo_oe), .hi_out(hi_out)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, ext_rst = 1'b0, code_int = 1'b0, req = 1'b0;
  logic [1:0] req_kind = 2'b11;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, lo_in = '0;
  logic busy, done, rst_qual, ale, psen_n, rd_n, wr_n, lo_oe;
  logic [7:0] rdata, hi_out, lo_out;
  int n_chk = 0, n_fail = 0;
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .code_int(code_int),
    .req(req), .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .rst_qual(rst_qual), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .hi_out(hi_out),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected pin levels by clock k of an access (k counted from 0).
  function automatic logic x_ale(input int k);  return k < 3; endfunction
  function automatic logic x_addr(input int k); return k < 4; endfunction
  function automatic logic x_stb(input int k);  return k > 4 && k < 11; endfunction

  task automatic idle_chk(input string tag);
    chk(!busy && !ale && psen_n && rd_n && wr_n && !lo_oe && hi_out == 8'h00,
        tag, {busy, ale, psen_n, rd_n, wr_n, lo_oe}, 6'b001110);
  endtask

  task automatic wait_busy();
    for (int n = 0; n < 30 && !busy; n++) @(negedge clk);
  endtask

  task automatic access(input logic [1:0] k, input logic [15:0] a,
                        input logic [7:0] w, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; req_kind = k; req_addr = a; req_wdata = w;
    wait_busy();
    chk(busy, "R2 accept", busy, 1);
    req = 1'b0; req_kind = 2'b11;
    for (int p = 0; p < 12; p++) begin
      lo_in = (p > 4) ? d : ~d;
      chk(busy && !done, "R2 busy window", {busy, done}, 2'b10);
      chk(hi_out == a[15:8], "R3 high byte", hi_out, a[15:8]);
      chk(ale == x_ale(p), "R4 ale", ale, x_ale(p));
      if (x_addr(p))
        chk(lo_oe && lo_out == a[7:0], "R4 low address", {lo_oe, lo_out}, {1'b1, a[7:0]});
      else if (k == 2'b10)
        chk(lo_oe && lo_out == w, "R6 write data", {lo_oe, lo_out}, {1'b1, w});
      else
        chk(!lo_oe, "R5 port released", lo_oe, 0);
      chk(psen_n == !(x_stb(p) && k == 2'b00), "R7 psen", psen_n, !(x_stb(p) && k == 2'b00));
      chk(rd_n == !(x_stb(p) && k == 2'b01), "R7 rd", rd_n, !(x_stb(p) && k == 2'b01));
      chk(wr_n == !(x_stb(p) && k == 2'b10), "R6 wr", wr_n, !(x_stb(p) && k == 2'b10));
      @(negedge clk);
    end
    if (k != 2'b10) last_rd = d;
    chk(done && !busy, "R2 done pulse", {done, busy}, 2'b10);
    chk(rdata == last_rd, (k == 2'b10) ? "R6 rdata kept" : "R5 rdata", rdata, last_rd);
    @(negedge clk);
    chk(!done, "R2 done width", done, 0);
  endtask

  task automatic ignored(input logic [1:0] k, input logic ci, input string tag);
    @(negedge clk);
    code_int = ci; req = 1'b1; req_kind = k; req_addr = 16'hA55A;
    for (int n = 0; n < 14; n++) begin
      @(negedge clk);
      chk(!busy && !ale && psen_n && rd_n && wr_n, tag, {busy, ale, psen_n, rd_n, wr_n}, 5'b00111);
    end
    req = 1'b0; req_kind = 2'b11; code_int = 1'b0;
  endtask

  task automatic rst_pulse(input int len);
    @(negedge clk);
    ext_rst = 1'b1;
    for (int n = 0; n < len; n++) begin
      @(negedge clk);
      chk(!rst_qual, "R10 short pulse", rst_qual, 0);
    end
    ext_rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst_n = 1'b1;
    repeat (15) @(negedge clk);
    idle_chk("R1 after reset");
    chk(!done && !rst_qual, "R1 flags", {done, rst_qual}, 0);

    access(2'b00, 16'h1234, 8'h00, 8'h5A);
    access(2'b01, 16'hFF00, 8'h00, 8'hC3);
    access(2'b10, 16'h00FF, 8'h96, 8'h11);

    for (int i = 0; i < 40; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 2));
      access(k, 16'($urandom()), 8'($urandom()), 8'($urandom()));
      repeat ($urandom_range(0, 13)) @(negedge clk);
    end

    ignored(2'b00, 1'b1, "R8 internal code");
    ignored(2'b11, 1'b0, "R8 no-op kind");

    // R9: request held through clock 11 chains a second access
    @(negedge clk);
    req = 1'b1; req_kind = 2'b01; req_addr = 16'h4411;
    wait_busy();
    req_kind = 2'b10; req_addr = 16'h8822; req_wdata = 8'h3C;
    repeat (12) @(negedge clk);
    chk(busy && done && ale && hi_out == 8'h88, "R9 chained start",
        {busy, done, ale, hi_out}, {3'b111, 8'h88});
    req = 1'b0; req_kind = 2'b11;
    repeat (12) @(negedge clk);
    chk(done && !busy, "R9 chained done", {done, busy}, 2'b10);

    // R10: short pulses and restart
    rst_pulse(23);
    @(negedge clk);
    chk(!rst_qual, "R10 after 23", rst_qual, 0);
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (20) @(negedge clk);
    ext_rst = 1'b0;
    @(negedge clk);
    ext_rst = 1'b1;
    repeat (20) @(negedge clk);
    chk(!rst_qual, "R10 restart", rst_qual, 0);
    ext_rst = 1'b0;
    @(negedge clk);

    // R10/R11: full qualification, requests refused meanwhile
    ext_rst = 1'b1;
    repeat (23) @(negedge clk);
    chk(!rst_qual, "R10 edge 23", rst_qual, 0);
    @(negedge clk);
    chk(rst_qual, "R10 edge 24", rst_qual, 1);
    req = 1'b1; req_kind = 2'b01;
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      chk(!busy && rst_qual, "R11 no accept", {busy, rst_qual}, 2'b01);
    end
    ext_rst = 1'b0;
    @(negedge clk);
    chk(!rst_qual, "R10 release", rst_qual, 0);
    wait_busy();
    chk(busy, "R11 accepts after release", busy, 1);
    req = 1'b0; req_kind = 2'b11;

    // R11: qualified reset in the middle of chained accesses
    @(negedge clk);
    req = 1'b1; req_kind = 2'b00; code_int = 1'b0;
    wait_busy();
    ext_rst = 1'b1;
    repeat (24) @(negedge clk);
    chk(rst_qual, "R11 qualified", rst_qual, 1);
    @(negedge clk);
    idle_chk("R11 access stopped");
    ext_rst = 1'b0; req = 1'b0; req_kind = 2'b11;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule